// File: doc/BRIEF.md
# Inclusive Snoop Forwarder

This block stands between the snoop port of an inclusive outer cache and the private inner caches behind it. The outer tag lookup tells it whether a bus snoop hits. Only snoops that touch a line an inner cache may hold are passed inward. For every outer line the block keeps one presence bit per inner cache and one flag. The flag marks a line that an inner cache holds modified while the outer copy still looks clean.

A read snoop that hits a line marked inner-dirty sends a data fetch to the inner holder. A read-exclusive snoop that hits sends an invalidate to every inner cache whose presence bit is set. When the outer cache evicts a line, the block first back-invalidates every inner copy, so inclusion still holds. In each of these cases the bus side is stalled, or the eviction is held, until every requested inner cache has acknowledged. Only one job is in progress at a time. Events reported by the inner caches (fill, write-upgrade, writeback, drop) keep the presence and dirty state up to date.

Top module: `incl_snoop_fwd`

## Requirements
- R1: After reset, snp_ready and evict_ready are high. No request, stall or done output is active, and every line has an empty presence set and a clear dirty flag.
- R2: A snoop accepted with snp_hit low sends no inner request. snp_done pulses in the cycle after acceptance, with done_inner_data low.
- R3: A read snoop (snp_excl low) that hits a line not marked inner-dirty sends no inner request. snp_done pulses in the cycle after acceptance.
- R4: A read snoop that hits an inner-dirty line sends fetch_req to the single holding inner cache. After the acknowledgement, snp_done pulses with done_inner_data high. The dirty flag is then cleared and the presence bit is kept.
- R5: A read-exclusive snoop (snp_excl high) that hits sends inv_req to every inner cache whose presence bit is set. done_inner_data is high when the line was inner-dirty. Afterwards the presence set and the dirty flag are both empty.
- R6: An accepted eviction back-invalidates every present inner cache, and evict_done pulses only in the cycle after the last acknowledgement. An eviction of a line with no presence completes in the cycle after acceptance. Afterwards the line has no presence.
- R7: Only one job is outstanding at a time. snp_ready and evict_ready stay low from acceptance until the done cycle has passed. When a snoop and an eviction are offered in the same idle cycle, the snoop is taken first.
- R8: An acknowledgement from an inner cache that was not asked is ignored. The job completes only after every requested cache has acknowledged.
- R9: Inner events are selected by ievt_op: 0 (fill) sets the presence bit of ievt_id. 1 (write-upgrade) makes ievt_id the only holder and sets the dirty flag. 2 (writeback) clears the dirty flag. 3 (drop) clears the presence bit of ievt_id and the dirty flag.
- R10: snp_stall is high from the cycle after a forwarded snoop is accepted until the last acknowledgement is received. It is low in the snp_done cycle.
- R11: inv_req and fetch_req are one-cycle pulses in the cycle after acceptance. req_idx carries the line index, and fetch and invalidate are never issued together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Bus snoop offered |
| snp_ready | output | 1 | Snoop accepted this cycle when high with snp_valid |
| snp_excl | input | 1 | 1 = read-exclusive snoop, 0 = read snoop |
| snp_hit | input | 1 | Outer tag lookup hit for the snooped line |
| snp_idx | input | IDX_W | Outer line index of the snoop |
| snp_stall | output | 1 | Snoop response held while inner acknowledgements are pending |
| snp_done | output | 1 | One-cycle pulse: snoop response may be given |
| done_inner_data | output | 1 | With snp_done or evict_done: inner cache supplied modified data |
| evict_valid | input | 1 | Outer eviction offered |
| evict_ready | output | 1 | Eviction accepted this cycle when high with evict_valid |
| evict_idx | input | IDX_W | Outer line index being evicted |
| evict_done | output | 1 | One-cycle pulse: evicted line may be released |
| ievt_valid | input | 1 | Inner cache event present |
| ievt_op | input | 2 | Inner event code (0 fill, 1 upgrade, 2 writeback, 3 drop) |
| ievt_id | input | ID_W | Inner cache reporting the event |
| ievt_idx | input | IDX_W | Outer line index of the event |
| inv_req | output | N_INNER | Invalidate pulse, one bit per inner cache |
| fetch_req | output | N_INNER | Data fetch pulse, one bit per inner cache |
| req_idx | output | IDX_W | Line index of the current inner request |
| inner_ack | input | N_INNER | Acknowledgement pulses, one bit per inner cache |

## Verification
A table of snoop patterns crosses hit and miss, read and read-exclusive, one to four present inner caches, and clean and inner-dirty lines. This separates "not forwarded" from "forwarded but nothing to do", and a fetch from an invalidate. Follow-up snoops to the same line show the state change after the job: dirty cleared while presence is kept after a fetch, and everything cleared after an invalidate or an eviction. Directed cases cover stray and partial acknowledgements, a snoop and an eviction offered in the same cycle, and each inner event code. Evictions are run with and without inner copies, so that the wait and the immediate completion can be told apart.

// File: rtl/snpfwd_pkg.sv
package snpfwd_pkg;
  typedef enum logic [1:0] {
    EV_FILL      = 2'd0,
    EV_UPGRADE   = 2'd1,
    EV_WRITEBACK = 2'd2,
    EV_DROP      = 2'd3
  } inner_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } eng_state_e;

  typedef enum logic [1:0] {
    JOB_RD    = 2'd0,
    JOB_RDX   = 2'd1,
    JOB_EVICT = 2'd2
  } job_e;

  function automatic logic job_is_fetch(job_e j);
    return j == JOB_RD;
  endfunction

  function automatic logic job_clears_presence(job_e j);
    return j != JOB_RD;
  endfunction
endpackage

// File: rtl/snpfwd_dir.sv
module snpfwd_dir
  import snpfwd_pkg::*;
#(
  parameter int N_INNER = 4,
  parameter int N_LINES = 16,
  parameter int IDX_W   = $clog2(N_LINES),
  parameter int ID_W    = $clog2(N_INNER)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [1:0]         ev_op,
  input  logic [ID_W-1:0]    ev_id,
  input  logic [IDX_W-1:0]   ev_idx,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic [N_INNER-1:0] lk_pres,
  output logic               lk_dirty,
  input  logic               upd_valid,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               upd_clr_pres
);
  logic [N_INNER-1:0] pres_q [N_LINES];
  logic [N_LINES-1:0] dirty_q;

  function automatic logic [N_INNER-1:0] id_bit(logic [ID_W-1:0] id);
    return {{(N_INNER-1){1'b0}}, 1'b1} << id;
  endfunction

  assign lk_pres  = pres_q[lk_idx];
  assign lk_dirty = dirty_q[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < N_LINES; l++) pres_q[l] <= '0;
      dirty_q <= '0;
    end else begin
      if (ev_valid) begin
        case (inner_op_e'(ev_op))
          EV_FILL: pres_q[ev_idx] <= pres_q[ev_idx] | id_bit(ev_id);
          EV_UPGRADE: begin
            pres_q[ev_idx]  <= id_bit(ev_id);
            dirty_q[ev_idx] <= 1'b1;
          end
          EV_WRITEBACK: dirty_q[ev_idx] <= 1'b0;
          EV_DROP: begin
            pres_q[ev_idx]  <= pres_q[ev_idx] & ~id_bit(ev_id);
            dirty_q[ev_idx] <= 1'b0;
          end
          default: ;
        endcase
      end
      // Job completion is written last, so it wins over an inner event on the same line.
      if (upd_valid) begin
        dirty_q[upd_idx] <= 1'b0;
        if (upd_clr_pres) pres_q[upd_idx] <= '0;
      end
    end
  end
endmodule

// File: rtl/snpfwd_acktrk.sv
module snpfwd_acktrk #(
  parameter int N_INNER = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_INNER-1:0] load_mask,
  input  logic [N_INNER-1:0] ack,
  output logic [N_INNER-1:0] pending,
  output logic               clear_next
);
  logic [N_INNER-1:0] pend_after;

  // Acks for caches that were not asked drop out through the mask.
  assign pend_after = pending & ~ack;
  assign clear_next = (pend_after == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    pending <= '0;
    else if (load) pending <= load_mask;
    else           pending <= pend_after;
  end
endmodule

// File: rtl/snpfwd_engine.sv
module snpfwd_engine
  import snpfwd_pkg::*;
#(
  parameter int N_INNER = 4,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snp_valid,
  input  logic               snp_excl,
  input  logic               snp_hit,
  input  logic [IDX_W-1:0]   snp_idx,
  input  logic               evict_valid,
  input  logic [IDX_W-1:0]   evict_idx,
  input  logic [N_INNER-1:0] lk_pres,
  input  logic               lk_dirty,
  input  logic               trk_clear,
  output logic [IDX_W-1:0]   lk_idx,
  output logic               trk_load,
  output logic [N_INNER-1:0] trk_mask,
  output logic               snp_ready,
  output logic               evict_ready,
  output logic               accept_snp,
  output logic               accept_ev,
  output logic [N_INNER-1:0] inv_req,
  output logic [N_INNER-1:0] fetch_req,
  output logic [IDX_W-1:0]   req_idx,
  output logic               snp_stall,
  output logic               snp_done,
  output logic               evict_done,
  output logic               done_inner_data,
  output logic               upd_valid,
  output logic [IDX_W-1:0]   upd_idx,
  output logic               upd_clr_pres,
  output logic               busy
);
  eng_state_e         state_q, state_d;
  job_e               job_q, job_in;
  logic [IDX_W-1:0]   idx_q;
  logic [N_INNER-1:0] mask_q;
  logic               hit_q, dirty_q;
  logic               hit_in;

  // Which inner caches a job must reach.
  function automatic logic [N_INNER-1:0] target_mask(job_e j, logic hit,
                                                     logic [N_INNER-1:0] pres,
                                                     logic dirty);
    case (j)
      JOB_RD:    return (hit && dirty) ? pres : '0;
      JOB_RDX:   return hit ? pres : '0;
      JOB_EVICT: return pres;
      default:   return '0;
    endcase
  endfunction

  assign snp_ready   = (state_q == ST_IDLE);
  assign evict_ready = (state_q == ST_IDLE) && !snp_valid;
  assign accept_snp  = snp_valid && snp_ready;
  assign accept_ev   = evict_valid && evict_ready;
  assign busy        = (state_q != ST_IDLE);

  assign lk_idx   = snp_valid ? snp_idx : evict_idx;
  assign job_in   = accept_snp ? (snp_excl ? JOB_RDX : JOB_RD) : JOB_EVICT;
  assign hit_in   = accept_snp ? snp_hit : 1'b1;
  assign trk_load = accept_snp || accept_ev;
  assign trk_mask = target_mask(job_in, hit_in, lk_pres, lk_dirty);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (trk_load) state_d = (trk_mask != '0) ? ST_ISSUE : ST_RESP;
      ST_ISSUE,
      ST_WAIT:  state_d = trk_clear ? ST_RESP : ST_WAIT;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      job_q   <= JOB_RD;
      idx_q   <= '0;
      mask_q  <= '0;
      hit_q   <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (trk_load) begin
        job_q   <= job_in;
        idx_q   <= lk_idx;
        mask_q  <= trk_mask;
        hit_q   <= hit_in;
        dirty_q <= hit_in && lk_dirty;
      end
    end
  end

  assign inv_req   = (state_q == ST_ISSUE && !job_is_fetch(job_q)) ? mask_q : '0;
  assign fetch_req = (state_q == ST_ISSUE &&  job_is_fetch(job_q)) ? mask_q : '0;
  assign req_idx   = idx_q;

  assign snp_stall       = (state_q == ST_ISSUE || state_q == ST_WAIT) && job_q != JOB_EVICT;
  assign snp_done        = (state_q == ST_RESP) && job_q != JOB_EVICT;
  assign evict_done      = (state_q == ST_RESP) && job_q == JOB_EVICT;
  assign done_inner_data = (state_q == ST_RESP) && dirty_q;

  assign upd_valid    = (state_q == ST_RESP) && hit_q;
  assign upd_idx      = idx_q;
  assign upd_clr_pres = job_clears_presence(job_q);
endmodule

// File: rtl/incl_snoop_fwd.sv
module incl_snoop_fwd
  import snpfwd_pkg::*;
#(
  parameter int N_INNER = 4,
  parameter int N_LINES = 16,
  parameter int IDX_W   = $clog2(N_LINES),
  parameter int ID_W    = $clog2(N_INNER)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snp_valid,
  output logic               snp_ready,
  input  logic               snp_excl,
  input  logic               snp_hit,
  input  logic [IDX_W-1:0]   snp_idx,
  output logic               snp_stall,
  output logic               snp_done,
  output logic               done_inner_data,
  input  logic               evict_valid,
  output logic               evict_ready,
  input  logic [IDX_W-1:0]   evict_idx,
  output logic               evict_done,
  input  logic               ievt_valid,
  input  logic [1:0]         ievt_op,
  input  logic [ID_W-1:0]    ievt_id,
  input  logic [IDX_W-1:0]   ievt_idx,
  output logic [N_INNER-1:0] inv_req,
  output logic [N_INNER-1:0] fetch_req,
  output logic [IDX_W-1:0]   req_idx,
  input  logic [N_INNER-1:0] inner_ack
);
  logic [IDX_W-1:0]   lk_idx, upd_idx;
  logic [N_INNER-1:0] lk_pres, trk_mask, pending;
  logic               lk_dirty, trk_load, trk_clear;
  logic               upd_valid, upd_clr_pres;
  logic               accept_snp, accept_ev, busy;

  snpfwd_dir #(.N_INNER(N_INNER), .N_LINES(N_LINES), .IDX_W(IDX_W), .ID_W(ID_W)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ievt_valid), .ev_op(ievt_op), .ev_id(ievt_id), .ev_idx(ievt_idx),
    .lk_idx(lk_idx), .lk_pres(lk_pres), .lk_dirty(lk_dirty),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_clr_pres(upd_clr_pres)
  );

  snpfwd_acktrk #(.N_INNER(N_INNER)) u_trk (
    .clk(clk), .rst_n(rst_n), .load(trk_load), .load_mask(trk_mask),
    .ack(inner_ack), .pending(pending), .clear_next(trk_clear)
  );

  snpfwd_engine #(.N_INNER(N_INNER), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_hit(snp_hit), .snp_idx(snp_idx),
    .evict_valid(evict_valid), .evict_idx(evict_idx),
    .lk_pres(lk_pres), .lk_dirty(lk_dirty), .trk_clear(trk_clear),
    .lk_idx(lk_idx), .trk_load(trk_load), .trk_mask(trk_mask),
    .snp_ready(snp_ready), .evict_ready(evict_ready),
    .accept_snp(accept_snp), .accept_ev(accept_ev),
    .inv_req(inv_req), .fetch_req(fetch_req), .req_idx(req_idx),
    .snp_stall(snp_stall), .snp_done(snp_done), .evict_done(evict_done),
    .done_inner_data(done_inner_data),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_clr_pres(upd_clr_pres),
    .busy(busy)
  );
endmodule

// File: rtl/incl_snoop_fwd_chk.sv
module incl_snoop_fwd_chk #(
  parameter int N_INNER = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               accept_snp,
  input logic               accept_ev,
  input logic               snp_hit,
  input logic               snp_ready,
  input logic               evict_ready,
  input logic               snp_stall,
  input logic               snp_done,
  input logic               evict_done,
  input logic               busy,
  input logic [N_INNER-1:0] inv_req,
  input logic [N_INNER-1:0] fetch_req,
  input logic [N_INNER-1:0] pending
);
  assert_single_job_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_snp || accept_ev) |=> (!snp_ready && !evict_ready));

  assert_no_dual_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_snp && accept_ev));

  assert_miss_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_snp && !snp_hit) |=> (snp_done && inv_req == '0 && fetch_req == '0));

  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((inv_req != '0) || (fetch_req != '0)) |=> (inv_req == '0 && fetch_req == '0));

  assert_req_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !((inv_req != '0) && (fetch_req != '0)));

  assert_fetch_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_req));

  assert_done_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_done |-> !snp_stall);

  assert_acks_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_done || evict_done) |-> (pending == '0 && busy));
endmodule

bind incl_snoop_fwd incl_snoop_fwd_chk #(.N_INNER(N_INNER)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept_snp(accept_snp), .accept_ev(accept_ev),
  .snp_hit(snp_hit), .snp_ready(snp_ready), .evict_ready(evict_ready),
  .snp_stall(snp_stall), .snp_done(snp_done), .evict_done(evict_done),
  .busy(busy), .inv_req(inv_req), .fetch_req(fetch_req), .pending(pending)
);

// File: tb/incl_snoop_fwd_tb.sv
module incl_snoop_fwd_tb;
  localparam int NI = 4;
  localparam int NL = 16;
  localparam int IW = 4;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snp_valid = 0, snp_excl = 0, snp_hit = 0;
  logic [IW-1:0] snp_idx = '0;
  logic evict_valid = 0;
  logic [IW-1:0] evict_idx = '0;
  logic ievt_valid = 0;
  logic [1:0] ievt_op = '0;
  logic [DW-1:0] ievt_id = '0;
  logic [IW-1:0] ievt_idx = '0;
  logic [NI-1:0] inner_ack = '0;
  logic snp_ready, snp_stall, snp_done, done_inner_data, evict_ready, evict_done;
  logic [NI-1:0] inv_req, fetch_req;
  logic [IW-1:0] req_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  incl_snoop_fwd #(.N_INNER(NI), .N_LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_excl(snp_excl),
    .snp_hit(snp_hit), .snp_idx(snp_idx), .snp_stall(snp_stall),
    .snp_done(snp_done), .done_inner_data(done_inner_data),
    .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_idx(evict_idx),
    .evict_done(evict_done),
    .ievt_valid(ievt_valid), .ievt_op(ievt_op), .ievt_id(ievt_id), .ievt_idx(ievt_idx),
    .inv_req(inv_req), .fetch_req(fetch_req), .req_idx(req_idx), .inner_ack(inner_ack)
  );

  // {hit, excl, fill[3:0], upg_v, upg_id[1:0], exp_inv[3:0], exp_fetch[3:0], exp_data}
  localparam int VN = 8;
  localparam logic [17:0] VEC [VN] = '{
    {1'b0, 1'b0, 4'b0011, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0},
    {1'b0, 1'b1, 4'b1111, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b0101, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b0101, 1'b1, 2'd2, 4'b0000, 4'b0100, 1'b1},
    {1'b1, 1'b1, 4'b1011, 1'b0, 2'd0, 4'b1011, 4'b0000, 1'b0},
    {1'b1, 1'b1, 4'b0001, 1'b1, 2'd3, 4'b1000, 4'b0000, 1'b1},
    {1'b1, 1'b1, 4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b1111, 1'b1, 2'd0, 4'b0000, 4'b0001, 1'b1}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic ievt(input logic [1:0] op, input int id, input int idx);
    ievt_valid = 1; ievt_op = op; ievt_id = DW'(id); ievt_idx = IW'(idx);
    @(negedge clk);
    ievt_valid = 0;
  endtask

  task automatic run_snoop(input int idx, input bit excl, input bit hit,
                           input logic [3:0] e_inv, input logic [3:0] e_fetch,
                           input bit e_data, input string rq);
    chk(snp_ready == 1'b1, rq, "snp_ready idle", snp_ready, 1);
    snp_valid = 1; snp_excl = excl; snp_hit = hit; snp_idx = IW'(idx);
    @(negedge clk);
    snp_valid = 0;
    if ((e_inv | e_fetch) != 4'b0) begin
      chk(inv_req == e_inv, rq, "inv_req", inv_req, e_inv);
      chk(fetch_req == e_fetch, rq, "fetch_req", fetch_req, e_fetch);
      chk(req_idx == IW'(idx), "R11", "req_idx", req_idx, idx);
      chk(snp_stall == 1'b1, "R10", "stall while pending", snp_stall, 1);
      chk(snp_ready == 1'b0, "R7", "ready while busy", snp_ready, 0);
      inner_ack = e_inv | e_fetch;
      @(negedge clk);
      inner_ack = '0;
    end
    chk(snp_done == 1'b1, rq, "snp_done", snp_done, 1);
    chk(done_inner_data == e_data, rq, "done_inner_data", done_inner_data, e_data);
    chk(snp_stall == 1'b0, "R10", "stall in done cycle", snp_stall, 0);
    chk((inv_req | fetch_req) == '0, "R11", "req after issue", inv_req | fetch_req, 0);
    @(negedge clk);
  endtask

  task automatic run_evict(input int idx, input logic [3:0] e_inv, input string rq);
    chk(evict_ready == 1'b1, rq, "evict_ready idle", evict_ready, 1);
    evict_valid = 1; evict_idx = IW'(idx);
    @(negedge clk);
    evict_valid = 0;
    if (e_inv != 4'b0) begin
      chk(inv_req == e_inv, rq, "back-invalidate", inv_req, e_inv);
      chk(evict_done == 1'b0, rq, "done before ack", evict_done, 0);
      chk(snp_stall == 1'b0, rq, "no bus stall on evict", snp_stall, 0);
      inner_ack = e_inv;
      @(negedge clk);
      inner_ack = '0;
    end
    chk(evict_done == 1'b1, rq, "evict_done", evict_done, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(snp_ready == 1'b1, "R1", "snp_ready", snp_ready, 1);
    chk(evict_ready == 1'b1, "R1", "evict_ready", evict_ready, 1);
    chk({inv_req, fetch_req} == '0, "R1", "requests", {inv_req, fetch_req}, 0);
    chk({snp_stall, snp_done, evict_done, done_inner_data} == 4'b0, "R1", "status",
        {snp_stall, snp_done, evict_done, done_inner_data}, 0);
    run_snoop(15, 1, 1, 4'b0, 4'b0, 0, "R1");

    // Table walk: R2 R3 R4 R5 with R9 fills/upgrades
    for (int i = 0; i < VN; i++) begin
      logic [17:0] v;
      string rq;
      v = VEC[i];
      for (int b = 0; b < NI; b++) if (v[12+b]) ievt(2'd0, b, i);
      if (v[11]) ievt(2'd1, int'(v[10:9]), i);
      rq = !v[17] ? "R2" : (v[16] ? "R5" : (v[4:1] != 0 ? "R4" : "R3"));
      run_snoop(i, v[16], v[17], v[8:5], v[4:1], v[0], rq);
    end

    // R4 follow-up: dirty cleared, presence (cache 2) kept
    run_snoop(3, 0, 1, 4'b0, 4'b0, 0, "R4");
    run_snoop(3, 1, 1, 4'b0100, 4'b0, 0, "R4");
    // R5 follow-up: presence cleared
    run_snoop(4, 1, 1, 4'b0, 4'b0, 0, "R5");

    // R9 writeback clears dirty; drop clears one presence bit
    ievt(2'd0, 1, 10); ievt(2'd1, 1, 10); ievt(2'd2, 1, 10);
    run_snoop(10, 0, 1, 4'b0, 4'b0, 0, "R9");
    ievt(2'd0, 0, 11); ievt(2'd0, 1, 11); ievt(2'd3, 0, 11);
    run_snoop(11, 1, 1, 4'b0010, 4'b0, 0, "R9");

    // R8 stray and partial acknowledgements
    ievt(2'd0, 0, 13); ievt(2'd0, 1, 13);
    snp_valid = 1; snp_excl = 1; snp_hit = 1; snp_idx = 4'd13;
    @(negedge clk);
    snp_valid = 0;
    chk(inv_req == 4'b0011, "R8", "inv_req", inv_req, 4'b0011);
    inner_ack = 4'b0101;
    @(negedge clk);
    inner_ack = '0;
    chk(snp_done == 1'b0, "R8", "done after partial ack", snp_done, 0);
    chk(snp_stall == 1'b1, "R8", "stall after partial ack", snp_stall, 1);
    chk(inv_req == 4'b0, "R11", "inv_req single pulse", inv_req, 0);
    inner_ack = 4'b1000;
    @(negedge clk);
    inner_ack = '0;
    chk(snp_done == 1'b0, "R8", "done after stray ack", snp_done, 0);
    inner_ack = 4'b0010;
    @(negedge clk);
    inner_ack = '0;
    chk(snp_done == 1'b1, "R8", "done after last ack", snp_done, 1);
    @(negedge clk);

    // R6 eviction with and without inner copies
    ievt(2'd0, 1, 9); ievt(2'd0, 2, 9);
    run_evict(9, 4'b0110, "R6");
    run_snoop(9, 1, 1, 4'b0, 4'b0, 0, "R6");
    run_evict(12, 4'b0, "R6");

    // R7 snoop wins over eviction offered in the same cycle
    snp_valid = 1; snp_excl = 0; snp_hit = 0; snp_idx = 4'd14;
    evict_valid = 1; evict_idx = 4'd12;
    #1;
    chk(evict_ready == 1'b0, "R7", "evict_ready with snoop", evict_ready, 0);
    chk(snp_ready == 1'b1, "R7", "snp_ready with evict", snp_ready, 1);
    @(negedge clk);
    snp_valid = 0;
    chk(snp_done == 1'b1, "R7", "snoop served first", snp_done, 1);
    chk(evict_ready == 1'b0, "R7", "evict_ready in done", evict_ready, 0);
    @(negedge clk);
    chk(evict_ready == 1'b1, "R7", "evict_ready after", evict_ready, 1);
    @(negedge clk);
    evict_valid = 0;
    chk(evict_done == 1'b1, "R7", "eviction served second", evict_done, 1);
    @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule